// File: doc/BRIEF.md
# Sound generator bus register file

This block sits on the receiving side of a two-line-controlled sound generator bus. Two control lines pick one of four bus states each clock cycle. The states are idle, read, write and address latch. An 8-bit data bus carries either a register index or a register value. The block keeps a 4-bit current register index and a file of sixteen 8-bit registers. All sixteen registers are presented in parallel to the downstream tone, noise, mixer and level logic.

A write is held open while the control lines stay in the write state. It commits only when that state ends, using the data seen in the last cycle of the write. In the idle state the bus is ignored completely, so a value left on the data lines between accesses never reaches a register. Register 0 is the fine period and register 1 the coarse period of the first tone channel. Register 7 is the channel enable mask and register 8 is the first channel's level. Level and coarse-period registers keep only the bits the downstream logic uses.

Top module: `psg_regfile`

## Requirements
- R1: After reset every register reads zero, and the current index is 0 and valid.
- R2: Control state {ctl_dir, ctl_sel} = 2'b11 with bus_data[7:4] = 0 sets the current index to bus_data[3:0] and marks it valid. The new index takes effect from the next clock edge.
- R3: Control state 2'b00 changes neither the index nor any register, whatever bus_data holds. The only exception is the commit of a write that has just ended.
- R4: Control state 2'b10 is a write. The register at the current index takes the bus_data value sampled in the last cycle of the 2'b10 run. The write commits on the first clock edge that samples a state other than 2'b10. Data seen earlier in the run, and data present at the commit edge, are not used.
- R5: Registers 1, 3 and 5 keep only bits [3:0]. Registers 8, 9 and 10 keep only bits [4:0]. All other registers keep all 8 bits. Bits that are not kept read as zero.
- R6: Control state 2'b01 drives the register at the current index on rd_data in the same cycle, and changes no state. In any other state rd_data is zero.
- R7: Control state 2'b11 with a nonzero bus_data[7:4] leaves the index unlatched and marks it invalid. Until a valid index is latched, writes change no register and reads return zero.
- R8: Register i appears on regs_flat[8*i+7 : 8*i] for i from 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_dir | input | 1 | Upper control line |
| ctl_sel | input | 1 | Lower control line |
| bus_data | input | 8 | Data bus carrying an index or a value |
| rd_data | output | 8 | Read-back of the register at the current index |
| regs_flat | output | 128 | All sixteen registers, register i at bits 8*i+7:8*i |

## Verification
The bench sweeps all sixteen indices with several data patterns. During each write the bus changes mid-write, and junk is placed on the bus at the commit edge. A design that committed at write entry, or on the edge where the write ends, would store the wrong byte. Long idle runs with moving data catch a design that lets the inactive bus leak into a register. An out-of-range index followed by a write and a read catches a design that wraps the index to its low nibble instead of ignoring the access. The bench also checks every register after each access, so a write that also touched another register, or that kept bits it should have masked, shows up.

// File: rtl/psg_regfile.sv
module psg_regfile #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_dir,
  input  logic                 ctl_sel,
  input  logic [DATA_W-1:0]    bus_data,
  output logic [DATA_W-1:0]    rd_data,
  output logic [16*DATA_W-1:0] regs_flat
);
  localparam int ADDR_W = 4;
  localparam int NREG   = 1 << ADDR_W;

  localparam logic [1:0] ST_IDLE = 2'b00;
  localparam logic [1:0] ST_RD   = 2'b01;
  localparam logic [1:0] ST_WR   = 2'b10;
  localparam logic [1:0] ST_LAT  = 2'b11;

  logic [1:0]        ctl;
  logic [DATA_W-1:0] regs [NREG];
  logic [ADDR_W-1:0] addr;
  logic              addr_ok;
  logic              pend;
  logic [DATA_W-1:0] hold;

  assign ctl = {ctl_dir, ctl_sel};

  function automatic logic [DATA_W-1:0] keep_mask(input logic [ADDR_W-1:0] idx);
    case (idx)
      4'd1, 4'd3, 4'd5:  keep_mask = DATA_W'(8'h0F);
      4'd8, 4'd9, 4'd10: keep_mask = DATA_W'(8'h1F);
      default:           keep_mask = '1;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      addr_ok <= 1'b1;
      pend    <= 1'b0;
      hold    <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      pend <= (ctl == ST_WR);
      if (ctl == ST_WR) hold <= bus_data;
      if (pend && ctl != ST_WR && addr_ok)
        regs[addr] <= hold & keep_mask(addr);
      if (ctl == ST_LAT) begin
        if (bus_data[DATA_W-1:ADDR_W] == '0) begin
          addr    <= bus_data[ADDR_W-1:0];
          addr_ok <= 1'b1;
        end else begin
          addr_ok <= 1'b0;
        end
      end
    end
  end

  assign rd_data = (ctl == ST_RD && addr_ok) ? regs[addr] : '0;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
  end
endmodule

// File: rtl/psg_regfile_chk.sv
module psg_regfile_chk #(
  parameter int DATA_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ctl_dir,
  input logic                 ctl_sel,
  input logic [DATA_W-1:0]    bus_data,
  input logic [DATA_W-1:0]    rd_data,
  input logic [16*DATA_W-1:0] regs_flat,
  input logic [3:0]           addr,
  input logic                 addr_ok
);
  logic [1:0] c;
  assign c = {ctl_dir, ctl_sel};

  a_r2_latch_index: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 2'b11 && bus_data[DATA_W-1:4] == '0) |=> (addr == $past(bus_data[3:0]) && addr_ok));

  a_r3_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 2'b00 && $past(c) != 2'b10) |=> ($stable(regs_flat) && $stable(addr)));

  a_r5_level_width: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_flat[8*DATA_W+5 +: 3] == 3'b0 && regs_flat[DATA_W+4 +: 4] == 4'b0));

  a_r6_read_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (c != 2'b01) |-> (rd_data == '0));

  a_r6_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 2'b01 && $past(c) != 2'b10) |=> $stable(regs_flat));

  a_r7_bad_index_held: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 2'b11 && bus_data[DATA_W-1:4] != '0) |=> ($stable(addr) && !addr_ok));
endmodule

bind psg_regfile psg_regfile_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/psg_regfile_tb.sv
`timescale 1ns/1ps
module psg_regfile_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctl_dir = 1'b0;
  logic         ctl_sel = 1'b0;
  logic [7:0]   bus_data = '0;
  logic [7:0]   rd_data;
  logic [127:0] regs_flat;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic [7:0] model [16];

  always #2 clk = ~clk;

  psg_regfile dut_i (.clk(clk), .rst_n(rst_n), .ctl_dir(ctl_dir), .ctl_sel(ctl_sel),
                     .bus_data(bus_data), .rd_data(rd_data), .regs_flat(regs_flat));

  function automatic logic [7:0] keep(input int idx, input logic [7:0] v);
    if (idx == 1 || idx == 3 || idx == 5) return v & 8'h0F;
    if (idx >= 8 && idx <= 10) return v & 8'h1F;
    return v;
  endfunction

  task automatic check_bank(input string req);
    for (int i = 0; i < 16; i++) begin
      vectors++;
      if (regs_flat[8*i +: 8] !== model[i]) begin
        errors++;
        $display("FAIL %s reg %0d actual %02h expected %02h", req, i, regs_flat[8*i +: 8], model[i]);
      end
    end
  endtask

  task automatic check_rd(input string req, input logic [7:0] exp);
    vectors++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s rd_data actual %02h expected %02h", req, rd_data, exp);
    end
  endtask

  task automatic latch(input logic [7:0] a);
    @(negedge clk); {ctl_dir, ctl_sel} = 2'b11; bus_data = a;
    @(negedge clk); {ctl_dir, ctl_sel} = 2'b00; bus_data = ~a;
  endtask

  task automatic write_val(input logic [7:0] v);
    @(negedge clk); {ctl_dir, ctl_sel} = 2'b10; bus_data = ~v;
    @(negedge clk); bus_data = v;
    @(negedge clk); {ctl_dir, ctl_sel} = 2'b00; bus_data = v ^ 8'h3C;
    @(negedge clk);
  endtask

  task automatic read_chk(input string req, input logic [7:0] exp);
    @(negedge clk); {ctl_dir, ctl_sel} = 2'b01; bus_data = 8'h77;
    #1 check_rd(req, exp);
    @(negedge clk); {ctl_dir, ctl_sel} = 2'b00;
  endtask

  initial begin
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    check_bank("R1 reset");
    check_rd("R1 reset rd idle", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check_bank("R1 after release");
    read_chk("R1 index 0 after reset", 8'h00);

    // R2 R4 R5 R8 sweep
    for (int a = 0; a < 16; a++) begin
      for (int p = 0; p < 5; p++) begin
        logic [7:0] v;
        v = (p < 4) ? pats[p] : 8'(a * 17 + 3);
        latch(8'(a));
        write_val(v);
        model[a] = keep(a, v);
        check_bank("R4/R5/R8 write sweep");
        read_chk("R6 read back", model[a]);
        check_bank("R6 read no change");
      end
    end

    // R3 idle with moving data
    latch(8'd7);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); {ctl_dir, ctl_sel} = 2'b00; bus_data = 8'(k * 29 + 1);
    end
    @(negedge clk);
    check_bank("R3 idle bus ignored");
    read_chk("R3 index kept", model[7]);

    // R7 out-of-range index
    latch(8'h35);
    write_val(8'hC3);
    check_bank("R7 write ignored");
    read_chk("R7 read zero", 8'h00);
    latch(8'hF0);
    write_val(8'h11);
    check_bank("R7 write ignored high");
    latch(8'h03);
    write_val(8'hC3);
    model[3] = keep(3, 8'hC3);
    check_bank("R7 recovery R5 mask");
    read_chk("R7 recovery read", 8'h03);

    // R2 latch back-to-back, last wins
    @(negedge clk); {ctl_dir, ctl_sel} = 2'b11; bus_data = 8'h02;
    @(negedge clk); bus_data = 8'h09;
    @(negedge clk); {ctl_dir, ctl_sel} = 2'b00;
    write_val(8'hEE);
    model[9] = keep(9, 8'hEE);
    check_bank("R2 last latch wins");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule